// File: doc/BRIEF.md
# Page buffer and write sequencer

This block sits behind the byte receiver of a two-wire serial memory slave. When a write transaction begins, it takes the starting address. It then collects each accepted data byte into a page-sized holding buffer and keeps a flag for every byte position that received data. The address pointer advances only within the page: the in-page bits count modulo the page size, and the page bits never change.

When the bus STOP arrives, the block runs one timed programming cycle of exactly `CYCLE_CLKS` system clocks and holds `busy` high for all of it. The receiver front end uses `busy` to withhold acknowledges. In the first slots of the cycle, every flagged position is erased to all ones. In the last slots, the same positions are written with their buffered bytes. Positions that were not flagged are never touched.

A write-protect input stops programming altogether. A STOP that arrives with protection active, or with no bytes collected, starts no cycle. When a cycle ends, the address counter points at the last byte that was entered.

Top module: `pgwr_seq`

## Requirements
- R1: During and right after reset, `busy` and `mem_we` are 0 and `addr_cnt` is 0.
- R2: Each `byte_valid` pulse taken while idle stores `byte_data` at in-page position `addr_cnt[PAGE_W-1:0]`. The position then increments modulo 2^PAGE_W, and the page bits `addr_cnt[ADDR_W-1:PAGE_W]` stay unchanged. `addr_load` sets `addr_cnt` to `start_addr` and clears all position flags.
- R3: The array is written only while `busy` is 1. `busy` rises in the clock after STOP is sampled and stays high for exactly `CYCLE_CLKS` clocks.
- R4: In one cycle, each flagged position receives exactly two array writes at `{page, position}`. The first write carries 8'hFF (erase). The second carries the byte last stored at that position.
- R5: No address outside the flagged positions of the current page is written.
- R6: With more than 2^PAGE_W bytes, the position wraps and later bytes replace earlier ones. A position that was overwritten is still programmed only once, with its final byte.
- R7: When `busy` falls, `addr_cnt` equals `{page, position of the last entered byte}`.
- R8: A STOP sampled with `wp` = 1 starts no cycle: `busy` stays 0 and the array is not written. `mem_we` is never 1 while `wp` is 1.
- R9: A STOP with no byte collected since the last `addr_load` or cycle starts no cycle and leaves `busy` at 0.
- R10: While `busy` is 1, `byte_valid`, `addr_load` and `stop` are ignored. Neither `addr_cnt` nor the bytes programmed in that cycle change because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load `start_addr` into the address counter and clear the flags |
| start_addr | input | ADDR_W | Starting address of a write transaction |
| byte_valid | input | 1 | One accepted data byte is on `byte_data` |
| byte_data | input | 8 | Write data byte |
| stop | input | 1 | Bus STOP seen |
| wp | input | 1 | Write protect, active high |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| addr_cnt | output | ADDR_W | Current address counter |

## Verification
The bench sweeps every starting position with burst lengths from one byte to two beyond a full page, and places the page bits on a different page in each sweep. Short bursts show that untouched positions stay intact. Bursts that cross the page end separate in-page wrapping from a carry into the page bits, and bursts longer than a page show that only the last byte at a position is kept and that it is programmed once. Protected STOPs, empty STOPs and traffic injected during a cycle each check that nothing is written and that the pointer is not disturbed.

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] addr_cnt
);
  localparam int NPOS  = 1 << PAGE_W;
  localparam int TW    = $clog2(CYCLE_CLKS);
  localparam int WR_AT = CYCLE_CLKS - NPOS;

  logic [ADDR_W-PAGE_W-1:0] page;
  logic [PAGE_W-1:0]        ptr;
  logic [NPOS-1:0]          valid;
  logic [7:0]               pbuf [NPOS];
  logic                     busy_q;
  logic [TW-1:0]            tmr;
  logic [TW-1:0]            woff;
  logic [PAGE_W-1:0]        pos;
  logic                     erase_ph, write_ph, last_tick;

  assign erase_ph  = busy_q && (tmr < TW'(NPOS));
  assign write_ph  = busy_q && (tmr >= TW'(WR_AT));
  assign last_tick = busy_q && (tmr == TW'(CYCLE_CLKS - 1));
  assign woff      = tmr - TW'(WR_AT);
  assign pos       = erase_ph ? tmr[PAGE_W-1:0] : woff[PAGE_W-1:0];

  assign busy      = busy_q;
  assign mem_we    = (erase_ph || write_ph) && valid[pos] && !wp;
  assign mem_addr  = {page, pos};
  assign mem_wdata = erase_ph ? 8'hFF : pbuf[pos];
  assign addr_cnt  = {page, ptr};

  always_ff @(posedge clk) begin
    if (!busy_q && !addr_load && byte_valid)
      pbuf[ptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page   <= '0;
      ptr    <= '0;
      valid  <= '0;
      busy_q <= 1'b0;
      tmr    <= '0;
    end else if (busy_q) begin
      if (last_tick) begin
        busy_q <= 1'b0;
        tmr    <= '0;
        valid  <= '0;
        ptr    <= ptr - 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (addr_load) begin
      page  <= start_addr[ADDR_W-1:PAGE_W];
      ptr   <= start_addr[PAGE_W-1:0];
      valid <= '0;
    end else if (byte_valid) begin
      valid[ptr] <= 1'b1;
      ptr        <= ptr + 1'b1;
    end else if (stop) begin
      if (|valid && !wp) busy_q <= 1'b1;
      else               valid  <= '0;
    end
  end
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              byte_valid,
  input logic              stop,
  input logic              wp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr_cnt
);
  localparam int CW = $clog2(CYCLE_CLKS + 2);
  logic [CW-1:0] bcnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      seen <= 1'b0;
    end else begin
      bcnt <= busy ? bcnt + 1'b1 : '0;
      if (busy) seen <= 1'b0;
      else if (addr_load) seen <= 1'b0;
      else if (byte_valid) seen <= 1'b1;
      else if (stop) seen <= 1'b0;
    end
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CW'(CYCLE_CLKS)));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));
  // R3
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8
  wp_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && wp && !busy && !addr_load && !byte_valid) |=> !busy);
  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && !seen && !addr_load && !byte_valid) |=> !busy);
  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !busy && !addr_load) |=> (addr_cnt[ADDR_W-1:PAGE_W] == $past(addr_cnt[ADDR_W-1:PAGE_W])));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(addr_cnt));
endmodule

bind pgwr_seq pgwr_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .byte_valid(byte_valid),
  .stop(stop), .wp(wp), .busy(busy), .mem_we(mem_we), .addr_cnt(addr_cnt)
);

// File: tb/tb_pgwr_seq.sv
module tb_pgwr_seq;
  localparam int AW = 6, PW = 4, CYC = 40, NA = 1 << AW, NP = 1 << PW;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_valid = 0, stop = 0, wp = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr, addr_cnt;
  logic [7:0] mem_wdata;

  pgwr_seq #(.ADDR_W(AW), .PAGE_W(PW), .CYCLE_CLKS(CYC)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [NA];
  logic [7:0] refm [NA];
  int wcnt [NA];
  logic [7:0] firstv [NA];

  always @(posedge clk) if (mem_we) begin
    if (wcnt[mem_addr] == 0) firstv[mem_addr] = mem_wdata;
    wcnt[mem_addr] = wcnt[mem_addr] + 1;
    mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dv(int s, int n, int i);
    return 8'(s * 29 + n * 13 + i * 7 + 1);
  endfunction

  task automatic run(int pg, int s, int n, bit wpv, bit inject);
    logic [AW-1:0] base;
    bit adr [NA];
    bit go;
    base = AW'(pg * NP);
    for (int a = 0; a < NA; a++) begin wcnt[a] = 0; adr[a] = 0; end
    @(negedge clk);
    addr_load = 1; start_addr = base | AW'(s);
    @(negedge clk);
    addr_load = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = dv(s, n, i);
      @(negedge clk);
    end
    byte_valid = 0;
    // R2: in-page position advanced modulo page, page bits kept
    chk(addr_cnt == (base | AW'((s + n) % NP)), "R2 addr_cnt during entry", addr_cnt, base | AW'((s + n) % NP));
    go = (n > 0) && !wpv;
    if (go) for (int i = 0; i < n; i++) begin
      refm[base | AW'((s + i) % NP)] = dv(s, n, i);
      adr[base | AW'((s + i) % NP)] = 1;
    end
    wp = wpv; stop = 1;
    @(negedge clk);
    stop = 0;
    if (go) begin
      chk(busy == 1, "R3 busy after STOP", busy, 1);
      if (inject) begin
        addr_load = 1; start_addr = ~base;
        byte_valid = 1; byte_data = 8'h3C; stop = 1;
        repeat (3) @(negedge clk);
        addr_load = 0; byte_valid = 0; stop = 0;
        repeat (CYC - 4) @(negedge clk);
      end else repeat (CYC - 1) @(negedge clk);
      chk(busy == 1, "R3 busy at last cycle clock", busy, 1);
      @(negedge clk);
      chk(busy == 0, "R3 busy low after cycle", busy, 0);
      // R7 (and R10 when injected)
      chk(addr_cnt == (base | AW'((s + n - 1) % NP)), inject ? "R10 R7 addr_cnt after cycle" : "R7 addr_cnt after cycle",
          addr_cnt, base | AW'((s + n - 1) % NP));
    end else begin
      repeat (CYC + 2) @(negedge clk);
      chk(busy == 0, wpv ? "R8 no cycle under wp" : "R9 no cycle on empty STOP", busy, 0);
    end
    begin
      int bad = -1;
      for (int a = 0; a < NA; a++)
        if (adr[a] ? (wcnt[a] != 2 || firstv[a] != 8'hFF) : (wcnt[a] != 0)) if (bad < 0) bad = a;
      chk(bad < 0, n > NP ? "R6 R4 R5 write pattern" : (go ? "R4 R5 write pattern" : (wpv ? "R8 no writes" : "R9 no writes")),
          bad < 0 ? 0 : wcnt[bad], bad < 0 ? 0 : (adr[bad] ? 2 : 0));
      bad = -1;
      for (int a = 0; a < NA; a++) if (mem[a] !== refm[a]) if (bad < 0) bad = a;
      chk(bad < 0, inject ? "R10 R4 array contents" : (n > NP ? "R6 array contents" : "R4 R5 array contents"),
          bad < 0 ? 0 : int'(mem[bad]), bad < 0 ? 0 : int'(refm[bad]));
    end
    wp = 0;
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NA; a++) begin mem[a] = 8'(a ^ 8'h5A); refm[a] = 8'(a ^ 8'h5A); end
    #1;
    // R1
    chk(busy == 0 && mem_we == 0 && addr_cnt == 0, "R1 state in reset", {busy, mem_we, addr_cnt}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0 && addr_cnt == 0, "R1 state after reset", {busy, mem_we, addr_cnt}, 0);
    for (int s = 0; s < NP; s++)
      for (int n = 1; n <= NP + 2; n++)
        run((s + n) % (NA / NP), s, n, 0, 0);
    for (int s = 0; s < NP; s++) run(s % (NA / NP), s, 4, 1, 0);
    for (int p = 0; p < NA / NP; p++) run(p, 5, 0, 0, 0);
    for (int s = 0; s < NP; s += 3) run(s % (NA / NP), s, 3, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule